// File: doc/BRIEF.md
# Vector Immediate Bit-Clear Unit

This unit decodes and executes a single vector operation: it clears bits in a vector register according to an 8-bit immediate. The immediate is shifted into place inside 16-bit or 32-bit lanes and copied into every lane of a 64-bit pattern. That pattern is repeated to cover the operating width. The unit inverts the pattern, ANDs it with the current contents of the destination register, and writes the result back to the same register.

A 32-entry, 128-bit register file sits inside the unit so that it can be tested on its own. A load port writes entries directly and an observe port reads any entry combinationally. Instructions enter through a valid/ready handshake. Back-pressure works as follows: `in_ready` is high only while no instruction is in flight. A word is taken on a clock edge where both `in_valid` and `in_ready` are high. `in_ready` then stays low for exactly the one cycle in which that instruction completes, so the unit accepts at most one instruction every two cycles. The trap input is sampled together with the accepted word.

Top module: `vbic_unit`

## Requirements
- R1: For a recognised, untrapped word with bit 30 (width select) = 1, the addressed register becomes `old & ~M`. M is the 64-bit lane pattern written twice. No bit that was 0 in `old` is ever set.
- R2: The 8-bit immediate is built from word bits 18:16 as its three most significant bits, followed by word bits 9:5 as its five least significant bits.
- R3: With cmode (word bits 15:12) equal to 0xx1, lanes are 32 bits wide. Each lane holds the immediate shifted left by 8 × cmode[2:1] bits, and each 64-bit pattern contains two such lanes.
- R4: With cmode equal to 10x1, lanes are 16 bits wide. Each lane holds the immediate shifted left by 8 × cmode[1] bits, and each 64-bit pattern contains four such lanes.
- R5: With bit 30 = 0, only the low 64 bits are computed as `old[63:0] & ~M`. Bits 127:64 of the register are written as zero.
- R6: A word is recognised only when all of the following hold: bit 31 = 0, bits 29:19 = 10111100000, bits 11:10 = 01, bit 12 = 1, and bits 15:14 ≠ 11. Any other accepted word raises `undef` in its done cycle and leaves every register unchanged.
- R7: A recognised word accepted while `trap_en` = 1 raises `trapped` in its done cycle and writes no register. `undef` takes priority over `trapped`, and both flags are low whenever `done` is low.
- R8: A word accepted on an edge produces `done` high for exactly the next cycle. During that cycle `in_ready` is low. The write lands at the end of that cycle.
- R9: After reset every register reads zero, `in_ready` is 1 and `done` is 0. A load (`ld_en`) writes `ld_data` into entry `ld_idx` on the clock edge, and `obs_data` always shows entry `obs_idx`.
- R10: The destination is the register whose index is in word bits 4:0. All other registers are left unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Unit can accept a word |
| in_instr | input | 32 | Instruction word |
| trap_en | input | 1 | Trap request, sampled with the accepted word |
| done | output | 1 | Completion pulse, one cycle after acceptance |
| trapped | output | 1 | Completed instruction was trapped (valid with done) |
| undef | output | 1 | Completed word was not recognised (valid with done) |
| ld_en | input | 1 | Direct register load strobe |
| ld_idx | input | 5 | Register index for load |
| ld_data | input | 128 | Data for load |
| obs_idx | input | 5 | Register index to observe |
| obs_data | output | 128 | Contents of the observed register |

## Verification
The assertions assume the load port is idle on any edge where the unit writes back. They also assume `in_instr` and `trap_en` hold known values whenever `in_valid` is high. The bench drives loads only between instructions, never during a done cycle, and always drives defined words. Random stimulus mixes legal encodings (all lane sizes, shifts and widths) with raw random words, plus undefined cmode values and trap requests. Directed cases pin down the shift extremes, the width-select zeroing and register isolation.

// File: rtl/vbic_pkg.sv
package vbic_pkg;
  localparam int INSTR_W  = 32;
  localparam int VEC_W    = 128;
  localparam int PAT_W    = 64;
  localparam int REG_N    = 32;
  localparam int IDX_W    = $clog2(REG_N);
  localparam logic [10:0] FIXED_OPC = 11'b10111100000;

  typedef struct packed {
    logic             hit;
    logic             wide;
    logic [7:0]       imm8;
    logic [3:0]       cmode;
    logic [IDX_W-1:0] dst;
  } dec_t;
endpackage

// File: rtl/vbic_decode.sv
module vbic_decode
  import vbic_pkg::*;
(
  input  logic [INSTR_W-1:0] word,
  output dec_t               dec
);
  logic opc_ok, low_ok, mode_ok;

  always_comb begin
    opc_ok  = (word[31] == 1'b0) && (word[29:19] == FIXED_OPC);
    low_ok  = (word[11:10] == 2'b01);
    // bit-clear flavour needs cmode[0]=1, and lane-size field 11 is rejected
    mode_ok = word[12] && (word[15:14] != 2'b11);
    dec.hit   = opc_ok && low_ok && mode_ok;
    dec.wide  = word[30];
    dec.imm8  = {word[18:16], word[9:5]};
    dec.cmode = word[15:12];
    dec.dst   = word[IDX_W-1:0];
  end
endmodule

// File: rtl/vbic_immexp.sv
module vbic_immexp
  import vbic_pkg::*;
#(
  parameter int OUT_W = VEC_W
) (
  input  logic [7:0]       imm8,
  input  logic [3:0]       cmode,
  output logic [OUT_W-1:0] mask
);
  localparam int REPS = OUT_W / PAT_W;
  localparam int N32  = PAT_W / 32;
  localparam int N16  = PAT_W / 16;

  logic [31:0]      lane32;
  logic [15:0]      lane16;
  logic [PAT_W-1:0] pat32, pat16, pat;

  always_comb begin
    lane32 = {24'b0, imm8} << {cmode[2:1], 3'b000};
    lane16 = {8'b0, imm8} << {cmode[1], 3'b000};
  end

  for (genvar i = 0; i < N32; i++) begin : g_l32
    assign pat32[i*32 +: 32] = lane32;
  end
  for (genvar i = 0; i < N16; i++) begin : g_l16
    assign pat16[i*16 +: 16] = lane16;
  end

  assign pat = cmode[3] ? pat16 : pat32;

  for (genvar r = 0; r < REPS; r++) begin : g_rep
    assign mask[r*PAT_W +: PAT_W] = pat;
  end

  // R3 R4: every lane keeps all immediate bits, none lost by the shift
  always_comb begin
    if (!$isunknown({imm8, cmode})) begin
      lane_pop_chk: assert ($countones(pat) ==
                            (cmode[3] ? N16 : N32) * $countones(imm8))
        else $error("lane pattern population mismatch");
    end
  end
endmodule

// File: rtl/vbic_regfile.sv
module vbic_regfile
  import vbic_pkg::*;
#(
  parameter int DEPTH = REG_N,
  parameter int WIDTH = VEC_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(DEPTH)-1:0] rd_a_idx,
  output logic [WIDTH-1:0]         rd_a_data,
  input  logic [$clog2(DEPTH)-1:0] rd_b_idx,
  output logic [WIDTH-1:0]         rd_b_data,
  input  logic                     wr_u_en,
  input  logic [$clog2(DEPTH)-1:0] wr_u_idx,
  input  logic [WIDTH-1:0]         wr_u_data,
  input  logic                     wr_l_en,
  input  logic [$clog2(DEPTH)-1:0] wr_l_idx,
  input  logic [WIDTH-1:0]         wr_l_data
);
  logic [WIDTH-1:0] mem [DEPTH];

  assign rd_a_data = mem[rd_a_idx];
  assign rd_b_data = mem[rd_b_idx];

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mem[e] <= '0;
      end else if (wr_u_en && wr_u_idx == e) begin
        mem[e] <= wr_u_data;
      end else if (wr_l_en && wr_l_idx == e) begin
        mem[e] <= wr_l_data;
      end
    end
  end

  // R10: a unit write lands in the addressed entry
  u_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_u_en |=> (mem[$past(wr_u_idx)] == $past(wr_u_data)))
    else $error("unit write not stored");

  // R9: load is taken when the unit is not writing
  l_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_l_en && !wr_u_en) |=> (mem[$past(wr_l_idx)] == $past(wr_l_data)))
    else $error("load not stored");
endmodule

// File: rtl/vbic_unit.sv
module vbic_unit
  import vbic_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [INSTR_W-1:0]   in_instr,
  input  logic                 trap_en,
  output logic                 done,
  output logic                 trapped,
  output logic                 undef,
  input  logic                 ld_en,
  input  logic [IDX_W-1:0]     ld_idx,
  input  logic [VEC_W-1:0]     ld_data,
  input  logic [IDX_W-1:0]     obs_idx,
  output logic [VEC_W-1:0]     obs_data
);
  localparam int HALF = VEC_W / 2;

  dec_t             dec;
  logic [VEC_W-1:0] mask, operand, result;
  logic             fire;

  logic             s_valid, s_trap, s_undef, s_wide;
  logic [IDX_W-1:0] s_idx;
  logic [VEC_W-1:0] s_res, s_oper;
  logic             rf_wen;

  vbic_decode u_dec (
    .word (in_instr),
    .dec  (dec)
  );

  vbic_immexp #(.OUT_W(VEC_W)) u_exp (
    .imm8  (dec.imm8),
    .cmode (dec.cmode),
    .mask  (mask)
  );

  vbic_regfile #(.DEPTH(REG_N), .WIDTH(VEC_W)) u_rf (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_a_idx  (dec.dst),
    .rd_a_data (operand),
    .rd_b_idx  (obs_idx),
    .rd_b_data (obs_data),
    .wr_u_en   (rf_wen),
    .wr_u_idx  (s_idx),
    .wr_u_data (s_res),
    .wr_l_en   (ld_en),
    .wr_l_idx  (ld_idx),
    .wr_l_data (ld_data)
  );

  assign in_ready = !s_valid;
  assign fire     = in_valid && in_ready;

  always_comb begin
    if (dec.wide) result = operand & ~mask;
    else          result = {{HALF{1'b0}}, operand[HALF-1:0] & ~mask[HALF-1:0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_valid <= 1'b0;
      s_trap  <= 1'b0;
      s_undef <= 1'b0;
      s_wide  <= 1'b0;
      s_idx   <= '0;
      s_res   <= '0;
      s_oper  <= '0;
    end else begin
      s_valid <= fire;
      if (fire) begin
        s_undef <= !dec.hit;
        s_trap  <= dec.hit && trap_en;
        s_wide  <= dec.wide;
        s_idx   <= dec.dst;
        s_res   <= result;
        s_oper  <= operand;
      end
    end
  end

  assign rf_wen  = s_valid && !s_trap && !s_undef;
  assign done    = s_valid;
  assign trapped = s_valid && s_trap;
  assign undef   = s_valid && s_undef;

  // R8
  accept_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> done)
    else $error("no done after accept");

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done)
    else $error("done longer than one cycle");

  // R7
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(trapped && undef))
    else $error("trapped and undef together");

  // R7
  flag_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (!trapped && !undef))
    else $error("flag without done");

  // R5
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_wen && !s_wide) |-> (s_res[VEC_W-1:HALF] == '0))
    else $error("upper half not zero for narrow width");

  // R1
  clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wen |-> ((s_res & ~s_oper) == '0))
    else $error("result sets a bit absent from operand");
endmodule

// File: tb/tb_vbic_unit.sv
module tb_vbic_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid, in_ready, trap_en;
  logic [31:0]  in_instr;
  logic         done, trapped, undef;
  logic         ld_en;
  logic [4:0]   ld_idx, obs_idx;
  logic [127:0] ld_data, obs_data;

  int checks = 0;
  int errors = 0;
  logic [127:0] model [32];

  vbic_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .trap_en(trap_en), .done(done), .trapped(trapped),
    .undef(undef), .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
    .obs_idx(obs_idx), .obs_data(obs_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] mk(logic q, logic [7:0] imm, logic [3:0] cm,
                                     logic [4:0] rd);
    return {1'b0, q, 11'b10111100000, imm[7:5], cm, 2'b01, imm[4:0], rd};
  endfunction

  function automatic logic is_bic(logic [31:0] w);
    return !w[31] && w[29:19] == 11'b10111100000 && w[11:10] == 2'b01 &&
           w[12] && w[15:14] != 2'b11;
  endfunction

  function automatic logic [127:0] exp_val(logic [31:0] w, logic [127:0] old);
    logic [7:0]  imm;
    logic [3:0]  cm;
    logic [31:0] l32;
    logic [15:0] l16;
    logic [63:0] p;
    imm = {w[18:16], w[9:5]};
    cm  = w[15:12];
    if (!cm[3]) begin
      l32 = 32'(imm) << (8 * cm[2:1]);
      p   = {l32, l32};
    end else begin
      l16 = 16'(imm) << (8 * cm[1]);
      p   = {l16, l16, l16, l16};
    end
    if (w[30]) return old & ~{p, p};
    return {64'b0, old[63:0] & ~p};
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic load(input logic [4:0] idx, input logic [127:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_idx = idx; ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
    model[idx] = d;
  endtask

  task automatic issue(input logic [31:0] w, input logic t, input logic [4:0] other);
    logic [4:0]   rd;
    logic         hit;
    logic [127:0] expv, keep;
    rd  = w[4:0];
    hit = is_bic(w);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_instr = w; trap_en = t;
    @(negedge clk);
    in_valid = 1'b0;
    chk(done === 1'b1, "R8 done", 128'(done), 128'(1));
    chk(in_ready === 1'b0, "R8 ready low in done cycle", 128'(in_ready), 128'(0));
    chk(undef === !hit, "R6 undef flag", 128'(undef), 128'(!hit));
    chk(trapped === (hit && t), "R7 trapped flag", 128'(trapped), 128'(hit && t));
    obs_idx = rd;
    keep = model[other];
    @(negedge clk);
    expv = (hit && !t) ? exp_val(w, model[rd]) : model[rd];
    chk(obs_data === expv, "R1 R5 R6 R7 result", obs_data, expv);
    model[rd] = expv;
    chk(done === 1'b0, "R8 done one cycle", 128'(done), 128'(0));
    if (other != rd) begin
      obs_idx = other;
      #1;
      chk(obs_data === keep, "R10 other register", obs_data, keep);
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; in_valid = 1'b0; in_instr = '0; trap_en = 1'b0;
    ld_en = 1'b0; ld_idx = '0; ld_data = '0; obs_idx = 5'd7;
    for (int i = 0; i < 32; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready === 1'b1, "R9 reset ready", 128'(in_ready), 128'(1));
    chk(done === 1'b0, "R9 reset done", 128'(done), 128'(0));
    chk(obs_data === '0, "R9 reset register zero", obs_data, '0);

    load(5'd3, {4{32'hFFFF_FFFF}});
    obs_idx = 5'd3; #1;
    chk(obs_data === {4{32'hFFFF_FFFF}}, "R9 load", obs_data, {4{32'hFFFF_FFFF}});

    // R3 all four 32-bit shifts, R2 immediate assembly
    issue(mk(1'b1, 8'hA5, 4'b0001, 5'd3), 1'b0, 5'd4);
    issue(mk(1'b1, 8'h81, 4'b0011, 5'd3), 1'b0, 5'd4);
    issue(mk(1'b1, 8'h3C, 4'b0101, 5'd3), 1'b0, 5'd4);
    issue(mk(1'b1, 8'hFF, 4'b0111, 5'd3), 1'b0, 5'd4);
    // R4 16-bit lanes, both shifts
    load(5'd9, {8{16'hFFFF}});
    issue(mk(1'b1, 8'h0F, 4'b1001, 5'd9), 1'b0, 5'd3);
    issue(mk(1'b1, 8'hF0, 4'b1011, 5'd9), 1'b0, 5'd3);
    // R5 narrow width zeroes the upper half
    load(5'd31, {4{32'h1234_5678}});
    issue(mk(1'b0, 8'h00, 4'b0001, 5'd31), 1'b0, 5'd0);
    // R6 cmode 11x1 and cmode[0]=0 rejected
    load(5'd12, {4{32'hDEAD_BEEF}});
    issue(mk(1'b1, 8'hFF, 4'b1101, 5'd12), 1'b0, 5'd3);
    issue(mk(1'b1, 8'hFF, 4'b0000, 5'd12), 1'b0, 5'd3);
    // R7 trap suppresses write; undef wins over trap
    issue(mk(1'b1, 8'hFF, 4'b0001, 5'd12), 1'b1, 5'd3);
    issue(mk(1'b1, 8'hFF, 4'b1111, 5'd12), 1'b1, 5'd3);

    for (int n = 0; n < 400; n++) begin
      logic [31:0] w;
      logic [3:0]  cm;
      if ($urandom % 4 == 0) load(5'($urandom), {$urandom, $urandom, $urandom, $urandom});
      cm = 4'($urandom);
      case ($urandom % 8)
        0:       w = $urandom;
        1:       w = mk(1'($urandom), 8'($urandom), cm, 5'($urandom)) ^ (32'h1 << ($urandom % 32));
        default: w = mk(1'($urandom), 8'($urandom), {cm[3], cm[3] ? 1'b0 : cm[2], cm[1], 1'b1},
                        5'($urandom));
      endcase
      issue(w, ($urandom % 8) == 0, 5'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule